// File: doc/BRIEF.md
# Fetch-Stage Instruction Decoder with Staged Control Delay

This block turns a 32-bit instruction word into every control signal the pipeline needs, and it does so in the fetch stage itself. There is no separate decode stage. The top four bits are the opcode. When the opcode's top bit is set the word uses the immediate layout: opcode, a 6-bit result-register field, a 6-bit source field and a 16-bit signed displacement. When that bit is clear the word uses the register layout: opcode, result register, two 6-bit source fields and ten spare bits. The source-register fields sit at the same bit positions in both layouts. The block therefore always presents them as register-file read addresses, before the format is known.

Controls that are needed later travel through three delay registers, one each for execute, memory and write-back. Each register loads only when its own stage's advance enable is high. If a stage advances while the stage feeding it holds, the stage receives an all-zero no-op bundle. Otherwise the held instruction would be copied into it. The execute bundle carries the opcode, the immediate select and the jump flag. The memory bundle carries the read, write and 64-bit width strobes. The write-back bundle carries the result-register number and its write or read strobe. That number is the write address for results and loads and the read address for stores.

There is no state machine here. Decoding is a single combinational case on an enumerated opcode type, and the three delay registers are the only state.

Top module: `instr_decoder`

## Requirements
- R1: `ra_o` = instr[21:16], `rb_o` = instr[15:10] and `rr_o` = instr[27:22] at all times, whatever the format and whatever the valid flag.
- R2: `imm_fmt_o` equals instr[31]. `disp_o` is instr[15:0] sign-extended to 32 bits from bit 15.
- R3: While `instr_valid_i` is high, the class outputs follow the opcode in instr[31:28]:
  - `is_alu_o` for opcodes 1, 3, 7 and 15.
  - `is_mem_o` for opcodes 10–13.
  - `is_branch_o` for opcode 14.
  - `is_cop_o` for opcodes 4, 5, 6, 9, 10 and 11.
  - `is_trap_o` for opcode 0.
  
  While `instr_valid_i` is low, all class outputs are 0.
- R4: Opcodes 2 and 8 with valid high drive `illegal_o`. They never produce a register write or a memory write in any stage.
- R5: A stage whose advance enable is high while the stage feeding it also advances captures that bundle on the clock edge. The fetch stage counts as always advancing. An invalid fetch enters execute as a no-op (`ex_valid_o` = 0).
- R6: The execute bundle holds the following:
  - `ex_valid_o`.
  - `ex_opcode_o`.
  - `ex_use_imm_o`, which is opcode bit 3.
  - `ex_branch_o`, which is set for opcode 14.
- R7: The memory bundle holds the following:
  - `mem_rd_o` for opcodes 11 and 13.
  - `mem_wr_o` for opcodes 10 and 12.
  - `mem_wide_o` for opcodes 10 and 11.
- R8: The write-back bundle carries the result register in `wb_rr_o`, and its strobes are set as follows:
  - `wb_rr_we_o` for opcodes 1, 3, 4, 7, 13 and 15.
  - `wb_rr_re_o` for opcodes 5 and 12.
- R9: A stage whose advance enable is low keeps its bundle unchanged.
- R10: A stage that advances while the stage feeding it holds becomes an all-zero no-op.
- R11: While `rst_n` is low, all three stage bundles are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| instr_i | input | 32 | Fetched instruction word |
| instr_valid_i | input | 1 | Fetched word is valid |
| adv_ex_i | input | 1 | Execute stage advance enable |
| adv_mem_i | input | 1 | Memory stage advance enable |
| adv_wb_i | input | 1 | Write-back stage advance enable |
| ra_o | output | 6 | First read address |
| rb_o | output | 6 | Second read address |
| rr_o | output | 6 | Result register field in fetch |
| imm_fmt_o | output | 1 | Immediate layout flag |
| disp_o | output | 32 | Sign-extended displacement |
| is_alu_o | output | 1 | Integer operation class |
| is_mem_o | output | 1 | Load/store class |
| is_branch_o | output | 1 | Conditional jump class |
| is_cop_o | output | 1 | Coprocessor class |
| is_trap_o | output | 1 | Trap class |
| illegal_o | output | 1 | Undefined or reserved opcode |
| ex_valid_o | output | 1 | Execute bundle valid |
| ex_opcode_o | output | 4 | Opcode in execute |
| ex_use_imm_o | output | 1 | Displacement operand select |
| ex_branch_o | output | 1 | Jump in execute |
| mem_valid_o | output | 1 | Memory bundle valid |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wide_o | output | 1 | 64-bit access |
| wb_valid_o | output | 1 | Write-back bundle valid |
| wb_rr_o | output | 6 | Result register in write-back |
| wb_rr_we_o | output | 1 | Result register write |
| wb_rr_re_o | output | 1 | Result register read for store/transfer |

## Verification
Two functions can fall in the same clock edge:
- One stage holds its bundle while the stage below it turns into a bubble.
- A new instruction enters execute in the cycle that the last one drains from write-back.

The bench provokes both by streaming every opcode back to back with all enables high. It checks the execute, memory and write-back bundles together at each edge against the opcode that entered one, two and three cycles earlier. It then lowers the execute enable while memory and write-back advance. In that edge it judges that execute is unchanged, memory is zero and write-back holds the former memory bundle.

// File: rtl/idec_pkg.sv
package idec_pkg;
    localparam int IW       = 32;
    localparam int OPC_W    = 4;
    localparam int REG_W    = 6;
    localparam int DISP_W   = 16;
    localparam int OPC_LSB  = IW - OPC_W;
    localparam int RR_LSB   = OPC_LSB - REG_W;
    localparam int RA_LSB   = RR_LSB - REG_W;
    localparam int RB_LSB   = RA_LSB - REG_W;
    localparam int NSTAGE   = 3;
    localparam int STG_EX   = 0;
    localparam int STG_MEM  = 1;
    localparam int STG_WB   = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_TRAP  = 4'd0,
        OP_EXTR  = 4'd1,
        OP_UNDEF = 4'd2,
        OP_VEXTR = 4'd3,
        OP_C2R   = 4'd4,
        OP_R2C   = 4'd5,
        OP_CALU  = 4'd6,
        OP_ALU   = 4'd7,
        OP_RSVD  = 4'd8,
        OP_CTEST = 4'd9,
        OP_CST   = 4'd10,
        OP_CLD   = 4'd11,
        OP_ST    = 4'd12,
        OP_LD    = 4'd13,
        OP_JCOND = 4'd14,
        OP_ADDI  = 4'd15
    } op_e;

    typedef struct packed {
        logic             valid;
        logic [OPC_W-1:0] opcode;
        logic [REG_W-1:0] rr;
        logic             use_imm;
        logic             branch;
        logic             mem_rd;
        logic             mem_wr;
        logic             mem_wide;
        logic             rr_we;
        logic             rr_re;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '0;
endpackage

// File: rtl/idec_decode.sv
module idec_decode
    import idec_pkg::*;
(
    input  logic [IW-1:0] instr_i,
    input  logic          valid_i,
    output ctrl_t         ctrl_o,
    output logic          alu_o,
    output logic          mem_o,
    output logic          branch_o,
    output logic          cop_o,
    output logic          trap_o,
    output logic          illegal_o
);
    op_e   op;
    ctrl_t raw;
    logic  c_alu, c_mem, c_br, c_cop, c_trap, c_ill;

    assign op = op_e'(instr_i[IW-1:OPC_LSB]);

    always_comb begin
        raw         = CTRL_NOP;
        raw.valid   = 1'b1;
        raw.opcode  = instr_i[IW-1:OPC_LSB];
        raw.rr      = instr_i[RR_LSB +: REG_W];
        raw.use_imm = instr_i[IW-1];
        c_alu  = 1'b0;
        c_mem  = 1'b0;
        c_br   = 1'b0;
        c_cop  = 1'b0;
        c_trap = 1'b0;
        c_ill  = 1'b0;
        unique case (op)
            OP_TRAP:  c_trap = 1'b1;
            OP_EXTR:  begin c_alu = 1'b1; raw.rr_we = 1'b1; end
            OP_UNDEF: c_ill = 1'b1;
            OP_VEXTR: begin c_alu = 1'b1; raw.rr_we = 1'b1; end
            OP_C2R:   begin c_cop = 1'b1; raw.rr_we = 1'b1; end
            OP_R2C:   begin c_cop = 1'b1; raw.rr_re = 1'b1; end
            OP_CALU:  c_cop = 1'b1;
            OP_ALU:   begin c_alu = 1'b1; raw.rr_we = 1'b1; end
            OP_RSVD:  c_ill = 1'b1;
            OP_CTEST: c_cop = 1'b1;
            OP_CST:   begin c_cop = 1'b1; c_mem = 1'b1;
                            raw.mem_wr = 1'b1; raw.mem_wide = 1'b1; end
            OP_CLD:   begin c_cop = 1'b1; c_mem = 1'b1;
                            raw.mem_rd = 1'b1; raw.mem_wide = 1'b1; end
            OP_ST:    begin c_mem = 1'b1; raw.mem_wr = 1'b1; raw.rr_re = 1'b1; end
            OP_LD:    begin c_mem = 1'b1; raw.mem_rd = 1'b1; raw.rr_we = 1'b1; end
            OP_JCOND: begin c_br = 1'b1; raw.branch = 1'b1; end
            OP_ADDI:  begin c_alu = 1'b1; raw.rr_we = 1'b1; end
        endcase
    end

    // Final gating level: an invalid fetch yields a no-op bundle and no class.
    assign ctrl_o    = valid_i ? raw : CTRL_NOP;
    assign alu_o     = valid_i & c_alu;
    assign mem_o     = valid_i & c_mem;
    assign branch_o  = valid_i & c_br;
    assign cop_o     = valid_i & c_cop;
    assign trap_o    = valid_i & c_trap;
    assign illegal_o = valid_i & c_ill;
endmodule

// File: rtl/idec_stage_reg.sv
module idec_stage_reg
    import idec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  up_adv_i,
    input  logic  own_adv_i,
    input  ctrl_t d_i,
    output ctrl_t q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= CTRL_NOP;
        else if (own_adv_i)
            q_o <= up_adv_i ? d_i : CTRL_NOP;
    end

    // R5: both advancing -> upstream bundle captured
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (own_adv_i && up_adv_i) |=> (q_o == $past(d_i)));
    // R9: stage held -> bundle unchanged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !own_adv_i |=> $stable(q_o));
    // R10: advance under a held upstream -> no-op
    a_r10_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (own_adv_i && !up_adv_i) |=> (q_o == CTRL_NOP));
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import idec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     instr_i,
    input  logic              instr_valid_i,
    input  logic              adv_ex_i,
    input  logic              adv_mem_i,
    input  logic              adv_wb_i,
    output logic [REG_W-1:0]  ra_o,
    output logic [REG_W-1:0]  rb_o,
    output logic [REG_W-1:0]  rr_o,
    output logic              imm_fmt_o,
    output logic [IW-1:0]     disp_o,
    output logic              is_alu_o,
    output logic              is_mem_o,
    output logic              is_branch_o,
    output logic              is_cop_o,
    output logic              is_trap_o,
    output logic              illegal_o,
    output logic              ex_valid_o,
    output logic [OPC_W-1:0]  ex_opcode_o,
    output logic              ex_use_imm_o,
    output logic              ex_branch_o,
    output logic              mem_valid_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              mem_wide_o,
    output logic              wb_valid_o,
    output logic [REG_W-1:0]  wb_rr_o,
    output logic              wb_rr_we_o,
    output logic              wb_rr_re_o
);
    ctrl_t             f_ctrl;
    ctrl_t             stg_d [NSTAGE];
    ctrl_t             stg_q [NSTAGE];
    logic [NSTAGE-1:0] adv;
    logic [NSTAGE-1:0] up_adv;

    // Fixed field positions let register reads start before format is known.
    assign ra_o      = instr_i[RA_LSB +: REG_W];
    assign rb_o      = instr_i[RB_LSB +: REG_W];
    assign rr_o      = instr_i[RR_LSB +: REG_W];
    assign imm_fmt_o = instr_i[IW-1];
    assign disp_o    = {{(IW-DISP_W){instr_i[DISP_W-1]}}, instr_i[DISP_W-1:0]};

    idec_decode u_dec (
        .instr_i   (instr_i),
        .valid_i   (instr_valid_i),
        .ctrl_o    (f_ctrl),
        .alu_o     (is_alu_o),
        .mem_o     (is_mem_o),
        .branch_o  (is_branch_o),
        .cop_o     (is_cop_o),
        .trap_o    (is_trap_o),
        .illegal_o (illegal_o)
    );

    assign adv = {adv_wb_i, adv_mem_i, adv_ex_i};

    genvar s;
    generate
        for (s = 0; s < NSTAGE; s++) begin : g_stage
            if (s == 0) begin : g_head
                assign stg_d[s]  = f_ctrl;
                assign up_adv[s] = 1'b1;
            end else begin : g_tail
                assign stg_d[s]  = stg_q[s-1];
                assign up_adv[s] = adv[s-1];
            end
            idec_stage_reg u_reg (
                .clk       (clk),
                .rst_n     (rst_n),
                .up_adv_i  (up_adv[s]),
                .own_adv_i (adv[s]),
                .d_i       (stg_d[s]),
                .q_o       (stg_q[s])
            );
        end
    endgenerate

    assign ex_valid_o   = stg_q[STG_EX].valid;
    assign ex_opcode_o  = stg_q[STG_EX].opcode;
    assign ex_use_imm_o = stg_q[STG_EX].use_imm;
    assign ex_branch_o  = stg_q[STG_EX].branch;
    assign mem_valid_o  = stg_q[STG_MEM].valid;
    assign mem_rd_o     = stg_q[STG_MEM].mem_rd;
    assign mem_wr_o     = stg_q[STG_MEM].mem_wr;
    assign mem_wide_o   = stg_q[STG_MEM].mem_wide;
    assign wb_valid_o   = stg_q[STG_WB].valid;
    assign wb_rr_o      = stg_q[STG_WB].rr;
    assign wb_rr_we_o   = stg_q[STG_WB].rr_we;
    assign wb_rr_re_o   = stg_q[STG_WB].rr_re;

    // R4: an illegal opcode entering execute carries no write strobe
    a_r4_illegal_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && adv_ex_i) |=> (ex_valid_o && !stg_q[STG_EX].rr_we
                                     && !stg_q[STG_EX].mem_wr));
    // R3: at most one of the exclusive classes
    a_r3_class_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_alu_o, is_branch_o, is_trap_o, illegal_o, is_mem_o && is_alu_o}));
    // R7: a memory bundle never reads and writes at once
    a_r7_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));
    // R8: result register is written or read, never both
    a_r8_wb_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_rr_we_o && wb_rr_re_o));
    // R6: execute valid follows the fetch valid one advance later
    a_r6_ex_valid: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ex_i |=> (ex_valid_o == $past(instr_valid_i)));
endmodule

// File: tb/instr_decoder_test.sv
module instr_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        vld = 1'b0;
    logic        aex = 1'b1, amem = 1'b1, awb = 1'b1;
    logic [5:0]  ra, rb, rr, wb_rr;
    logic        immf, alu, mem, br, cop, trap, ill;
    logic [31:0] disp;
    logic        exv, exi, exb, memv, mrd, mwr, mwide, wbv, we, re;
    logic [3:0]  exop;
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;

    always #10 clk = ~clk;

    instr_decoder uut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .instr_valid_i(vld),
        .adv_ex_i(aex), .adv_mem_i(amem), .adv_wb_i(awb),
        .ra_o(ra), .rb_o(rb), .rr_o(rr), .imm_fmt_o(immf), .disp_o(disp),
        .is_alu_o(alu), .is_mem_o(mem), .is_branch_o(br), .is_cop_o(cop),
        .is_trap_o(trap), .illegal_o(ill),
        .ex_valid_o(exv), .ex_opcode_o(exop), .ex_use_imm_o(exi), .ex_branch_o(exb),
        .mem_valid_o(memv), .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_wide_o(mwide),
        .wb_valid_o(wbv), .wb_rr_o(wb_rr), .wb_rr_we_o(we), .wb_rr_re_o(re)
    );

    // {instr, flags}; flags = alu,mem,br,cop,trap,ill,we,re,mrd,mwr,mwide
    localparam logic [42:0] VEC [16] = '{
        {32'h0123_4567, 11'b00001000000},
        {32'h1FED_8001, 11'b10000010000},
        {32'h2A5A_5A5A, 11'b00000100000},
        {32'h3C00_03FF, 11'b10000010000},
        {32'h4444_4444, 11'b00010010000},
        {32'h57C1_F00D, 11'b00010001000},
        {32'h6000_0000, 11'b00010000000},
        {32'h7FFF_FFFF, 11'b10000010000},
        {32'h8765_8000, 11'b00000100000},
        {32'h9ABC_7FFF, 11'b00010000000},
        {32'hA0C3_1234, 11'b01010000011},
        {32'hB3F0_FEDC, 11'b01010000101},
        {32'hC841_0004, 11'b01000001010},
        {32'hD5C3_FFFC, 11'b01000010100},
        {32'hE03F_8888, 11'b00100000000},
        {32'hF9D2_0010, 11'b10000010000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] f_ex(int j);
        if (j < 0 || j > 15) return '0;
        return {1'b1, VEC[j][42], VEC[j][8], VEC[j][42:39]};
    endfunction
    function automatic logic [3:0] f_mem(int j);
        if (j < 0 || j > 15) return '0;
        return {1'b1, VEC[j][2], VEC[j][1], VEC[j][0]};
    endfunction
    function automatic logic [8:0] f_wb(int j);
        if (j < 0 || j > 15) return '0;
        return {1'b1, VEC[j][38:33], VEC[j][4], VEC[j][3]};
    endfunction

    task automatic chk_stages(input string tag, input int je, input int jm, input int jw);
        chk({tag, " R6 ex"},  {exv, exi, exb, exop}, f_ex(je));
        chk({tag, " R7 mem"}, {memv, mrd, mwr, mwide}, f_mem(jm));
        chk({tag, " R8 wb"},  {wbv, wb_rr, we, re}, f_wb(jw));
    endtask

    task automatic drive(input int j);
        instr = VEC[j][42:11];
        vld   = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk_stages("R11 reset", -1, -1, -1);
        rst_n = 1'b1;

        // Table walk: all opcodes back to back, every stage checked each edge
        for (int i = 0; i < 19; i++) begin
            chk_stages("R5 stream", i - 1, i - 2, i - 3);
            if (i < 16) begin
                drive(i);
                #1;
                chk("R3 R4 class", {alu, mem, br, cop, trap, ill}, VEC[i][10:5]);
                chk("R1 R2 fields", {rr, ra, rb, immf, disp},
                    {VEC[i][38:33], VEC[i][32:27], VEC[i][26:21], VEC[i][42],
                     {16{VEC[i][26]}}, VEC[i][26:11]});
            end else begin
                vld   = 1'b0;
                instr = '0;
            end
            @(negedge clk);
        end

        // R1 R2 R3: fields extracted with valid low, classes silent
        instr = 32'h8ABC_F00F;
        vld   = 1'b0;
        #1;
        chk("R1 invalid fields", {ra, rb, rr}, {6'h3C, 6'h3C, 6'h2A});
        chk("R2 neg disp", {immf, disp}, {1'b1, 32'hFFFF_F00F});
        chk("R3 invalid class", {alu, mem, br, cop, trap, ill}, 6'b0);
        vld = 1'b1;
        #1;
        chk("R4 reserved flag", ill, 1'b1);
        @(negedge clk);

        // Fill: WB=13, MEM=12, EX=15
        drive(13); @(negedge clk);
        drive(12); @(negedge clk);
        drive(15); @(negedge clk);
        chk_stages("R5 fill", 15, 12, 13);
        // R9: all held
        drive(1);
        aex = 1'b0; amem = 1'b0; awb = 1'b0;
        @(negedge clk);
        chk_stages("R9 hold", 15, 12, 13);
        // R10: EX holds while MEM and WB advance
        amem = 1'b1; awb = 1'b1;
        @(negedge clk);
        chk_stages("R10 bubble mem", 15, -1, 12);
        // R10: MEM holds, WB advances, EX loads
        aex = 1'b1; amem = 1'b0;
        @(negedge clk);
        chk_stages("R10 bubble wb", 1, -1, -1);

        // R11: reset mid-run
        amem = 1'b1;
        drive(7); @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_stages("R11 midreset", -1, -1, -1);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule